// File: doc/BRIEF.md
# Signed-Digit Pre-Encoded Multiplier Datapath

This block multiplies an N-bit two's-complement multiplicand by a coefficient that was recoded ahead of time into radix-4 signed digits. The coefficient arrives as N+1 bits. Each lower digit takes two bits and uses a four-value digit set. The most significant digit takes three bits in Booth form: sign, magnitude-two and magnitude-one. A parameter picks which four-value set the lower digits use. The "minus" set is {-2,-1,0,+1}; the "plus" set is {-1,0,+1,+2}.

Every lower digit pair goes through a small decoder. The decoder produces a negate flag and a magnitude select (one or two). A row generator then builds an (N+1)-bit partial product from A, sign-extended by one bit. For a negative digit the row is inverted, and a carry-in restores the two's-complement value. The rows are weighted by 4^j and summed together with their carry-ins and a constant that accounts for the complemented row sign bits. The product is 2N bits wide, taken modulo 2^(2N).

The datapath has one register stage at the input and one at the output. A valid bit travels alongside the data. Results appear two clock edges after they are accepted.

Top module: `sd_premul`

## Requirements
- R1: With VARIANT minus, `out_prod` equals `in_a` times the coefficient value, as signed numbers, modulo 2^(2N). The least significant product bit equals `in_a[0]` AND `in_coef[0]`.
- R2: With VARIANT plus, `out_prod` equals `in_a` times the coefficient value, as signed numbers, modulo 2^(2N).
- R3: In the minus variant, a lower digit j (j < N/2-1) is encoded as hi = `in_coef[2j+1]` and lo = `in_coef[2j]`. Its value is -2·hi + lo, and it carries weight 4^j.
- R4: In the plus variant, a lower digit j is encoded as hi = `in_coef[2j+1]` and lo = `in_coef[2j]`. Its value is 2·hi − lo, and it carries weight 4^j.
- R5: The top digit has weight 4^(N/2-1). Its fields are sign = `in_coef[N]`, two = `in_coef[N-1]` and one = `in_coef[N-2]`. Its value is (−1)^sign·(one + 2·two). When one and two are both clear, the value is 0 whatever the sign bit is.
- R6: `out_valid` is high exactly two rising edges after the edge at which `in_valid` was sampled high.
- R7: When no result is completed, `out_prod` keeps its previous value.
- R8: After reset, `out_valid` is 0 and `out_prod` is 0.
- R9: A zero multiplicand, or an all-zero coefficient word, gives a product of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands on `in_a`/`in_coef` are valid this cycle |
| in_a | input | N_W | Two's-complement multiplicand |
| in_coef | input | N_W+1 | Recoded coefficient (lower digit pairs, then top sign/two/one) |
| out_valid | output | 1 | `out_prod` holds a new result |
| out_prod | output | 2*N_W | Product modulo 2^(2N) |

## Verification
The bench targets several corner cases:

- **Multiplicand at its most negative value times a digit of magnitude two.** This produces a row whose negation does not fit in N+1 bits. A design that drops the carry-in, or that forgets to complement the row sign bit before adding the constant, gives results that are off by a power of two.
- **Every pair code at every digit position, in both variants.** A decoder with the polarity swapped returns −d instead of d.
- **The top digit with the sign bit set and zero magnitude.** A generator that treats the sign as a bare negate would add a stray carry.
- **Valid gaps.** These expose a product register that is reloaded on idle cycles, or a valid bit that is out of step with the data by a cycle.

// File: rtl/sd_premul_pkg.sv
package sd_premul_pkg;

  typedef enum logic {
    SD_MINUS = 1'b0,
    SD_PLUS  = 1'b1
  } sd_variant_e;

  // per-digit row controls: negate the row, pick |d| = 1 or |d| = 2
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } sd_ctl_t;

endpackage

// File: rtl/sd_digit_decode.sv
module sd_digit_decode
  import sd_premul_pkg::*;
#(
  parameter sd_variant_e VARIANT = SD_MINUS
) (
  input  logic [1:0] pair,
  output sd_ctl_t    ctl
);

  logic hi, lo;
  logic pos_one, neg_one, dbl;

  assign hi = pair[1];
  assign lo = pair[0];

  generate
    if (VARIANT == SD_MINUS) begin : g_minus
      // value = -2*hi + lo
      assign pos_one = ~hi & lo;
      assign neg_one = hi & lo;
      assign dbl     = hi & ~lo;       // -2
      assign ctl.neg = neg_one | dbl;
    end else begin : g_plus
      // value = 2*hi - lo
      assign pos_one = hi & lo;
      assign neg_one = ~hi & lo;
      assign dbl     = hi & ~lo;       // +2
      assign ctl.neg = neg_one;
    end
  endgenerate

  assign ctl.one = pos_one | neg_one;
  assign ctl.two = dbl;

endmodule

// File: rtl/sd_pp_row.sv
module sd_pp_row
  import sd_premul_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] a,
  input  sd_ctl_t       ctl,
  output logic [AW:0]   row,
  output logic          cin
);

  logic [AW:0] ext;
  logic [AW:0] sel;

  always_comb begin
    ext = {a[AW-1], a};
    if (ctl.two)      sel = {ext[AW-1:0], 1'b0};
    else if (ctl.one) sel = ext;
    else              sel = '0;
    row = ctl.neg ? ~sel : sel;
  end

  // negation completed by +1 at the row's weight
  assign cin = ctl.neg;

endmodule

// File: rtl/sd_row_sum.sv
module sd_row_sum #(
  parameter int AW   = 16,
  parameter int ROWS = 8,
  localparam int PW  = 2 * AW
) (
  input  logic [ROWS-1:0][AW:0] rows,
  input  logic [ROWS-1:0]       cins,
  output logic [PW-1:0]         prod
);

  // constant that compensates the complemented row sign bits
  function automatic logic [PW-1:0] cor_fn();
    logic [PW-1:0] c;
    c = PW'(1);
    for (int j = 0; j < ROWS; j++) c = c + (PW'(1) << (2 * j + 1));
    return c << AW;
  endfunction

  localparam logic [PW-1:0] COR_K = cor_fn();

  logic [PW-1:0] term [ROWS];

  genvar gr;
  generate
    for (gr = 0; gr < ROWS; gr++) begin : g_term
      assign term[gr] = ({{(PW-AW-1){1'b0}}, ~rows[gr][AW], rows[gr][AW-1:0]}
                         + PW'(cins[gr])) << (2 * gr);
    end
  endgenerate

  logic [PW-1:0] acc;

  always_comb begin
    acc = COR_K;
    for (int r = 0; r < ROWS; r++) acc = acc + term[r];
    prod = acc;
  end

endmodule

// File: rtl/sd_premul.sv
module sd_premul
  import sd_premul_pkg::*;
#(
  parameter int          N_W     = 16,
  parameter sd_variant_e VARIANT = SD_MINUS,
  localparam int         K       = N_W / 2,
  localparam int         PW      = 2 * N_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [N_W-1:0] in_a,
  input  logic [N_W:0]   in_coef,
  output logic          out_valid,
  output logic [PW-1:0] out_prod
);

  // stage 1: operand registers
  logic           s1_valid;
  logic [N_W-1:0] s1_a;
  logic [N_W:0]   s1_coef;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_a     <= '0;
      s1_coef  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_a    <= in_a;
        s1_coef <= in_coef;
      end
    end
  end

  // digit controls
  sd_ctl_t [K-1:0]      ctl;
  logic [K-1:0][N_W:0]  rows;
  logic [K-1:0]         cins;
  logic [PW-1:0]        sum_prod;

  genvar gj;
  generate
    for (gj = 0; gj < K - 1; gj++) begin : g_dec
      sd_digit_decode #(.VARIANT(VARIANT)) u_dec (
        .pair (s1_coef[2*gj+1:2*gj]),
        .ctl  (ctl[gj])
      );
    end
  endgenerate

  // top digit in Booth form: sign / two / one
  assign ctl[K-1].neg = s1_coef[N_W];
  assign ctl[K-1].two = s1_coef[N_W-1];
  assign ctl[K-1].one = s1_coef[N_W-2];

  generate
    for (gj = 0; gj < K; gj++) begin : g_row
      sd_pp_row #(.AW(N_W)) u_row (
        .a   (s1_a),
        .ctl (ctl[gj]),
        .row (rows[gj]),
        .cin (cins[gj])
      );
    end
  endgenerate

  sd_row_sum #(.AW(N_W), .ROWS(K)) u_sum (
    .rows (rows),
    .cins (cins),
    .prod (sum_prod)
  );

  // stage 2: result register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_prod <= sum_prod;
    end
  end

endmodule

// File: rtl/sd_premul_chk.sv
module sd_premul_chk #(
  parameter int  N_W = 16,
  localparam int PW  = 2 * N_W
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           s1_valid,
  input logic [N_W-1:0] s1_a,
  input logic [N_W:0]   s1_coef,
  input logic           out_valid,
  input logic [PW-1:0]  out_prod
);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid); // R6

  AST_IDLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(out_prod)); // R7

  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && (s1_a == '0 || s1_coef == '0)) |=> (out_prod == '0)); // R9

  AST_PRODUCT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> (out_prod[0] == $past(s1_a[0] & s1_coef[0]))); // R1

endmodule

bind sd_premul sd_premul_chk #(.N_W(N_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .s1_valid  (s1_valid),
  .s1_a      (s1_a),
  .s1_coef   (s1_coef),
  .out_valid (out_valid),
  .out_prod  (out_prod)
);

// File: tb/sd_premul_bench.sv
`timescale 1ns/1ps
module sd_premul_bench;
  import sd_premul_pkg::*;

  localparam int N  = 16;
  localparam int K  = N / 2;
  localparam int PW = 2 * N;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          in_valid;
  logic [N-1:0]  in_a;
  logic [N:0]    coef_m, coef_p;
  logic          ov_m, ov_p;
  logic [PW-1:0] prod_m, prod_p;

  sd_premul #(.N_W(N), .VARIANT(SD_MINUS)) u_sd_premul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a),
    .in_coef(coef_m), .out_valid(ov_m), .out_prod(prod_m));

  sd_premul #(.N_W(N), .VARIANT(SD_PLUS)) u_sd_premul_plus (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a),
    .in_coef(coef_p), .out_valid(ov_p), .out_prod(prod_p));

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // two-deep reference pipeline
  logic          h_v  [2];
  logic [PW-1:0] h_em [2];
  logic [PW-1:0] h_ep [2];
  string         h_tm [2];
  string         h_tp [2];
  logic [PW-1:0] last_m, last_p;

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] mul_ref(input logic [N-1:0] a, input longint bval);
    longint p;
    p = longint'($signed(a)) * bval;
    return p[PW-1:0];
  endfunction

  // value of a coefficient word read from the requirement tables
  function automatic longint coef_val(input logic [N:0] c, input bit plus);
    longint v = 0;
    longint w = 1;
    longint d, mag;
    for (int j = 0; j < K - 1; j++) begin
      if (plus) d = 2 * longint'(c[2*j+1]) - longint'(c[2*j]);
      else      d = longint'(c[2*j]) - 2 * longint'(c[2*j+1]);
      v = v + d * w;
      w = w * 4;
    end
    mag = longint'(c[N-2]) + 2 * longint'(c[N-1]);
    v = v + (c[N] ? -mag : mag) * w;
    return v;
  endfunction

  // serial recoder of a two's-complement word into the coefficient format
  function automatic logic [N:0] recode(input logic [N-1:0] b, input bit plus);
    logic [N:0] r = '0;
    bit c = 0;
    bit b0, b1, c1, lo, hi;
    int v, mag;
    for (int j = 0; j < K - 1; j++) begin
      b0 = b[2*j];
      b1 = b[2*j+1];
      lo = b0 ^ c;
      c1 = plus ? (b0 | c) : (b0 & c);
      hi = b1 ^ c1;
      c  = plus ? (b1 & c1) : (b1 | c1);
      r[2*j]   = lo;
      r[2*j+1] = hi;
    end
    v   = -2 * int'(b[N-1]) + int'(b[N-2]) + int'(c);
    mag = (v < 0) ? -v : v;
    r[N]   = (v < 0);
    r[N-1] = (mag == 2);
    r[N-2] = (mag == 1);
    return r;
  endfunction

  task automatic step(input logic v, input logic [N-1:0] a,
                      input logic [N:0] cm, input logic [N:0] cp,
                      input logic [PW-1:0] em, input logic [PW-1:0] ep,
                      input string tm, input string tp);
    @(negedge clk);
    check("R6", PW'(ov_m), PW'(h_v[1]));
    check("R6", PW'(ov_p), PW'(h_v[1]));
    if (h_v[1]) begin
      check(h_tm[1], prod_m, h_em[1]);
      check(h_tp[1], prod_p, h_ep[1]);
      last_m = h_em[1];
      last_p = h_ep[1];
    end else begin
      check("R7", prod_m, last_m);
      check("R7", prod_p, last_p);
    end
    h_v[1] = h_v[0];  h_em[1] = h_em[0]; h_ep[1] = h_ep[0];
    h_tm[1] = h_tm[0]; h_tp[1] = h_tp[0];
    h_v[0] = v; h_em[0] = em; h_ep[0] = ep; h_tm[0] = tm; h_tp[0] = tp;
    in_valid = v;
    in_a     = a;
    coef_m   = cm;
    coef_p   = cp;
  endtask

  task automatic mul_pair(input logic [N-1:0] a, input logic [N-1:0] b, input logic v);
    logic [N:0] cm, cp;
    longint bv;
    cm = recode(b, 1'b0);
    cp = recode(b, 1'b1);
    bv = longint'($signed(b));
    step(v, a, cm, cp, mul_ref(a, bv), mul_ref(a, bv), "R1", "R2");
  endtask

  task automatic raw_coef(input logic [N-1:0] a, input logic [N:0] c, input string tg);
    step(1'b1, a, c, c, mul_ref(a, coef_val(c, 1'b0)), mul_ref(a, coef_val(c, 1'b1)),
         (tg == "") ? "R3" : tg, (tg == "") ? "R4" : tg);
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      h_v[i] = 0; h_em[i] = '0; h_ep[i] = '0; h_tm[i] = ""; h_tp[i] = "";
    end
    last_m = '0; last_p = '0;
    rst_n = 1'b0; in_valid = 1'b0; in_a = '0; coef_m = '0; coef_p = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    check("R8", PW'(ov_m), '0);
    check("R8", prod_m, '0);
    check("R8", PW'(ov_p), '0);
    check("R8", prod_p, '0);

    // R3 / R4: every pair code at every lower digit position
    for (int j = 0; j < K - 1; j++) begin
      for (int pc = 0; pc < 4; pc++) begin
        logic [N:0] c;
        c = '0;
        c[2*j]   = pc[0];
        c[2*j+1] = pc[1];
        raw_coef(N'($urandom), c, "");
        raw_coef(N'(1), c, "");
      end
    end

    // R5: top digit fields, including sign set with zero magnitude
    for (int sg = 0; sg < 2; sg++) begin
      for (int mg = 0; mg < 3; mg++) begin
        logic [N:0] c;
        c = '0;
        c[N]   = sg[0];
        c[N-1] = (mg == 2);
        c[N-2] = (mg == 1);
        raw_coef(N'(1), c, "R5");
        raw_coef({1'b1, {(N-1){1'b0}}}, c, "R5");
        raw_coef(N'($urandom), c | (N+1)'($urandom & 32'h3FFF), "R5");
      end
    end

    // R9: zero operands
    raw_coef('0, (N+1)'($urandom), "R9");
    raw_coef(N'($urandom), '0, "R9");

    // R7: idle gaps between results
    step(1'b0, N'($urandom), '0, '0, '0, '0, "R7", "R7");
    step(1'b0, N'($urandom), (N+1)'($urandom), (N+1)'($urandom), '0, '0, "R7", "R7");
    step(1'b0, '0, '0, '0, '0, '0, "R7", "R7");

    // R1 / R2: extremes
    begin
      logic [N-1:0] ext [6];
      ext[0] = {1'b1, {(N-1){1'b0}}};
      ext[1] = {1'b0, {(N-1){1'b1}}};
      ext[2] = '0;
      ext[3] = '1;
      ext[4] = N'(1);
      ext[5] = {1'b1, {(N-2){1'b0}}, 1'b1};
      for (int x = 0; x < 6; x++)
        for (int y = 0; y < 6; y++)
          mul_pair(ext[x], ext[y], 1'b1);
    end

    // R1 / R2: random pairs with random valid gaps (R6, R7)
    for (int i = 0; i < 10000; i++) begin
      mul_pair(N'($urandom), N'($urandom), 1'b1);
      if (($urandom & 3) == 0) step(1'b0, N'($urandom), (N+1)'($urandom),
                                    (N+1)'($urandom), '0, '0, "R7", "R7");
    end

    // drain
    repeat (3) step(1'b0, '0, '0, '0, '0, '0, "R7", "R7");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule